// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider with Fault Detection

This block divides a double-width dividend, given as an upper and a lower half of N bits each, by an N-bit divisor. It returns an N-bit quotient and an N-bit remainder. The caller selects unsigned or two's-complement operation for each request. A request is accepted when `start` is high while the unit is idle. The unit then runs a restoring shift-subtract loop of exactly N steps, one step per clock. It reports the result with a one-cycle `done` pulse.

If the result cannot be represented, the unit raises `fault` together with `done` and returns zero in place of the quotient and remainder. This happens when the divisor is zero or when the quotient does not fit in N bits. The unit detects a zero divisor, or an upper dividend half that is already too large, before the loop starts, and reports those faults early. In signed mode the sign fix-up after the loop applies an asymmetric range check: a negative quotient may reach -2^(N-1), but a positive quotient must stay below 2^(N-1). The remainder always takes the sign of the dividend. A packed copy of the result, remainder above quotient, is also provided. For N = 8 this is the usual 16-bit form with the remainder in the upper byte.

Top module: `idiv_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `fault` are 0, and `quot`, `rem` and `packed_res` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is 1 from the next cycle until `done` rises. `done` is high for exactly one cycle and is never high together with `busy`.
- R3: A zero divisor in either mode gives `done` with `fault`=1 exactly 1 clock edge after the accepting edge.
- R4: If the magnitude of the upper dividend half is greater than or equal to the magnitude of the divisor, the fault is reported with the same 1-edge latency as in R3. In unsigned mode the magnitudes are the raw values. In signed mode they are taken after two's-complement negation of the 2N-bit dividend and of the divisor.
- R5: In unsigned mode, a non-faulting request gives `quot` = floor({hi,lo}/dvsr) and `rem` = {hi,lo} mod dvsr. `done` rises exactly N+1 edges after the accepting edge, including when the upper half is zero.
- R6: In signed mode (`signed_mode`=1), the quotient is truncated toward zero. The remainder is zero or carries the sign of the dividend, so that quot*dvsr + rem equals the dividend.
- R7: In signed mode, a quotient of -2^(N-1) is valid when the operand signs differ. A quotient of +2^(N-1) or more when the signs match faults, and this late fault arrives with the N+1-edge latency.
- R8: A `start` pulse while `busy` is high is ignored: the running request's result is unchanged, and no extra `done` follows.
- R9: `packed_res` equals {`rem`, `quot`} at all times.
- R10: Whenever `fault` is 1, `quot` and `rem` are both zero. Results and `fault` hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; taken only when idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dvd_hi | input | N | Upper half of the 2N-bit dividend |
| dvd_lo | input | N | Lower half of the 2N-bit dividend |
| dvsr | input | N | Divisor |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| fault | output | 1 | Zero divisor or quotient out of range |
| quot | output | N | Quotient (zero on fault) |
| rem | output | N | Remainder (zero on fault) |
| packed_res | output | 2N | {rem, quot} |

## Verification
Early faults (zero divisor, or an upper half that is too large) are due exactly 1 rising edge after the accepting edge. Every other outcome, including the late signed range fault, is due exactly N+1 edges after it. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting edge until `done` appears, then compares that count with the latency its own reference predicts for the operands. The quotient, remainder, packed word and fault flag are sampled in that same `done` cycle, and `busy` is checked to be low there. For the ignored-start case, a second request is driven in the middle of the run, and the bench confirms that the first request's result and latency are unchanged.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    // per-request control carried alongside the datapath
    typedef struct packed {
        logic sgn;        // signed request
        logic neg_dvd;    // dividend was negative
        logic neg_dvs;    // divisor was negative
        logic early_flt;  // fault known before the loop
    } div_ctl_t;

endpackage

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         sgn,
    input  logic [N-1:0] hi,
    input  logic [N-1:0] lo,
    input  logic [N-1:0] dv,
    output logic [N-1:0] m_hi,
    output logic [N-1:0] m_lo,
    output logic [N-1:0] m_dv,
    output div_ctl_t     ctl
);
    localparam int W = 2 * N;

    logic [W-1:0] whole;
    logic [W-1:0] wmag;

    always_comb begin
        whole           = {hi, lo};
        ctl.sgn         = sgn;
        ctl.neg_dvd     = sgn & hi[N-1];
        ctl.neg_dvs     = sgn & dv[N-1];
        wmag            = ctl.neg_dvd ? (W'(0) - whole) : whole;
        m_dv            = ctl.neg_dvs ? (N'(0) - dv) : dv;
        m_hi            = wmag[W-1:N];
        m_lo            = wmag[N-1:0];
        // zero divisor, or the quotient cannot fit in N bits
        ctl.early_flt   = (dv == '0) || (m_hi >= m_dv);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int N = 16
) (
    input  logic [N-1:0] part,
    input  logic [N-1:0] low,
    input  logic [N-1:0] den,
    output logic [N-1:0] part_nx,
    output logic [N-1:0] low_nx
);
    logic         top;
    logic [N-1:0] sh;
    logic         take;

    always_comb begin
        top     = part[N-1];
        sh      = {part[N-2:0], low[N-1]};
        take    = top || (sh >= den);
        part_nx = take ? (sh - den) : sh;
        low_nx  = {low[N-2:0], take};
    end
endmodule

// File: rtl/div_fix.sv
module div_fix
    import div_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] qmag,
    input  logic [N-1:0] rmag,
    input  div_ctl_t     ctl,
    output logic [N-1:0] q_out,
    output logic [N-1:0] r_out,
    output logic         range_flt
);
    localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};

    logic neg_q;

    always_comb begin
        neg_q = ctl.neg_dvd ^ ctl.neg_dvs;
        if (!ctl.sgn) begin
            q_out     = qmag;
            r_out     = rmag;
            range_flt = 1'b0;
        end else begin
            // negative side may reach HALF, positive side must stay below
            range_flt = neg_q ? (qmag > HALF) : (qmag >= HALF);
            q_out     = neg_q ? (N'(0) - qmag) : qmag;
            r_out     = ctl.neg_dvd ? (N'(0) - rmag) : rmag;
        end
    end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
    import div_pkg::*;
#(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [N-1:0]   dvd_hi,
    input  logic [N-1:0]   dvd_lo,
    input  logic [N-1:0]   dvsr,
    output logic           busy,
    output logic           done,
    output logic           fault,
    output logic [N-1:0]   quot,
    output logic [N-1:0]   rem,
    output logic [2*N-1:0] packed_res
);
    localparam int CW = $clog2(N) + 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    div_state_e   st;
    logic [CW-1:0] cnt;
    logic [N-1:0] part_q, low_q, den_q;
    div_ctl_t     ctl_q;

    logic [N-1:0] m_hi, m_lo, m_dv;
    div_ctl_t     ctl_in;
    logic [N-1:0] part_nx, low_nx;
    logic [N-1:0] fq, fr;
    logic         range_flt;

    div_prep #(.N(N)) u_prep (
        .sgn (signed_mode), .hi (dvd_hi), .lo (dvd_lo), .dv (dvsr),
        .m_hi(m_hi), .m_lo(m_lo), .m_dv(m_dv), .ctl(ctl_in)
    );

    div_step #(.N(N)) u_step (
        .part(part_q), .low(low_q), .den(den_q),
        .part_nx(part_nx), .low_nx(low_nx)
    );

    div_fix #(.N(N)) u_fix (
        .qmag(low_q), .rmag(part_q), .ctl(ctl_q),
        .q_out(fq), .r_out(fr), .range_flt(range_flt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            part_q <= '0;
            low_q  <= '0;
            den_q  <= '0;
            ctl_q  <= '0;
            done   <= 1'b0;
            fault  <= 1'b0;
            quot   <= '0;
            rem    <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        part_q <= m_hi;
                        low_q  <= m_lo;
                        den_q  <= m_dv;
                        ctl_q  <= ctl_in;
                        cnt    <= '0;
                        st     <= ctl_in.early_flt ? ST_FIX : ST_RUN;
                    end
                end
                ST_RUN: begin
                    part_q <= part_nx;
                    low_q  <= low_nx;
                    cnt    <= cnt + 1'b1;
                    if (cnt == LAST) st <= ST_FIX;
                end
                ST_FIX: begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                    if (ctl_q.early_flt || range_flt) begin
                        fault <= 1'b1;
                        quot  <= '0;
                        rem   <= '0;
                    end else begin
                        fault <= 1'b0;
                        quot  <= fq;
                        rem   <= fr;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign packed_res = {rem, quot};

    // R2: handshake shape
    p_done_not_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: zero divisor faults one edge after acceptance
    p_zero_div_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && dvsr == '0) |=> ##1 (done && fault));

    // R4: oversize upper half faults early
    p_early_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ctl_in.early_flt) |=> ##1 (done && fault));

    // R5: unsigned remainder smaller than divisor
    p_urem_small_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !fault && !ctl_q.sgn) |-> (rem < den_q));

    // R6: signed remainder follows dividend sign
    p_srem_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !fault && ctl_q.sgn && rem != '0) |-> (rem[N-1] == ctl_q.neg_dvd));

    // R7: signed quotient sign consistent with operand signs
    p_squot_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !fault && ctl_q.sgn && quot != '0)
            |-> (quot[N-1] == (ctl_q.neg_dvd ^ ctl_q.neg_dvs)));

    // R8: captured divisor untouched while a request runs
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && st != ST_FIX) |=> $stable(den_q));

    // R10: a fault leaves zero results
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (quot == '0 && rem == '0));
endmodule

// File: tb/tb_idiv_unit.sv
module tb_idiv_unit;
    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic           signed_mode;
    logic [N-1:0]   dvd_hi, dvd_lo, dvsr;
    logic           busy, done, fault;
    logic [N-1:0]   quot, rem;
    logic [2*N-1:0] packed_res;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    idiv_unit #(.N(N)) dut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
        .busy(busy), .done(done), .fault(fault),
        .quot(quot), .rem(rem), .packed_res(packed_res)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input logic sgn, input logic [N-1:0] hi, lo, d,
                         output logic e_flt, output logic e_early,
                         output logic [N-1:0] e_q, output logic [N-1:0] e_r);
        longint num, den, q, r, mag, md;
        if (!sgn) begin
            num = longint'({hi, lo});
            den = longint'(d);
        end else begin
            num = longint'($signed({hi, lo}));
            den = longint'($signed(d));
        end
        mag = (num < 0) ? -num : num;
        md  = (den < 0) ? -den : den;
        e_early = (den == 0) || ((mag >>> N) >= md);
        e_flt   = e_early;
        e_q = '0;
        e_r = '0;
        if (!e_early) begin
            q = num / den;
            r = num % den;
            if (sgn && (q > (longint'(1) <<< (N-1)) - 1 || q < -(longint'(1) <<< (N-1))))
                e_flt = 1'b1;
            if (!e_flt) begin
                e_q = q[N-1:0];
                e_r = r[N-1:0];
            end
        end
    endtask

    // run one request; inject_at >= 0 drives a second start while busy
    task automatic run_div(input string req, input logic sgn,
                           input logic [N-1:0] hi, lo, d, input int inject_at);
        logic e_flt, e_early;
        logic [N-1:0] e_q, e_r;
        int lat;
        model(sgn, hi, lo, d, e_flt, e_early, e_q, e_r);
        @(negedge clk);
        signed_mode = sgn; dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        check("R2", "busy after accept", longint'(busy), 1);
        while (!done && lat < 4 * N) begin
            if (lat == inject_at) begin
                signed_mode = ~sgn; dvd_hi = '0; dvd_lo = 16'h1234; dvsr = 16'h0003;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(req, "latency", longint'(lat), e_early ? 1 : N + 1);
        check(req, "fault", longint'(fault), longint'(e_flt));
        check(req, "quot", longint'(quot), longint'(e_q));
        check(req, "rem", longint'(rem), longint'(e_r));
        check("R9", "packed", longint'(packed_res), longint'({e_r, e_q}));
        check("R2", "busy low at done", longint'(busy), 0);
        @(negedge clk);
        check("R2", "done one cycle", longint'(done), 0);
        check("R10", "held quot", longint'(quot), longint'(e_q));
        check("R10", "held fault", longint'(fault), longint'(e_flt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] h, l, d;
        logic s;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; start = 1'b0; signed_mode = 1'b0;
        dvd_hi = '0; dvd_lo = '0; dvsr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", longint'(busy), 0);
        check("R1", "done", longint'(done), 0);
        check("R1", "fault", longint'(fault), 0);
        check("R1", "packed", longint'(packed_res), 0);

        run_div("R5", 1'b0, 16'h0000, 16'd100, 16'd7, -1);
        run_div("R5", 1'b0, 16'h0000, 16'h0000, 16'd9, -1);
        run_div("R5", 1'b0, 16'hFFFE, 16'hFFFF, 16'hFFFF, -1);
        run_div("R3", 1'b0, 16'h0001, 16'h0002, 16'h0000, -1);
        run_div("R3", 1'b1, 16'hFFFF, 16'hFFF0, 16'h0000, -1);
        run_div("R4", 1'b0, 16'h0007, 16'h0000, 16'h0007, -1);
        run_div("R4", 1'b1, 16'h8000, 16'h0000, 16'hFFFF, -1);
        run_div("R6", 1'b1, 16'hFFFF, 16'hFFF9, 16'h0002, -1);  // -7/2
        run_div("R6", 1'b1, 16'h0000, 16'h0007, 16'hFFFE, -1);  //  7/-2
        run_div("R6", 1'b1, 16'hFFFF, 16'hFFF9, 16'hFFFE, -1);  // -7/-2
        run_div("R7", 1'b1, 16'hFFFF, 16'h0000, 16'h0002, -1);  // -65536/2 ok
        run_div("R7", 1'b1, 16'h0001, 16'h0000, 16'hFFFE, -1);  // 65536/-2 ok
        run_div("R7", 1'b1, 16'h0001, 16'h0000, 16'h0002, -1);  // +32768 late fault
        run_div("R7", 1'b1, 16'hFFFF, 16'h0000, 16'hFFFE, -1);  // -65536/-2 late fault
        run_div("R8", 1'b0, 16'h0012, 16'h3456, 16'h00F1, 3);
        run_div("R8", 1'b1, 16'hFFFF, 16'h8001, 16'h0101, 0);

        for (int k = 0; k < 300; k++) begin
            s = 1'($urandom);
            d = 16'($urandom);
            l = 16'($urandom);
            if (k % 4 == 0) h = 16'($urandom);
            else h = 16'($urandom % 8);
            if (s && $urandom % 2 == 1) h = ~h;
            if (k % 37 == 0) d = '0;
            run_div(s ? "R6" : "R5", s, h, l, d, (k % 5 == 0) ? int'($urandom % N) : -1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule